// File: doc/BRIEF.md
# NAND Flash Strobe Timing Controller

This block converts single host read or write requests into timed cycles on an asynchronous NAND flash bus. Each access runs through three phases: setup, strobe-low and hold. Each phase lasts its programmed value plus one system clock cycle. A fourth value sets when the write data starts to drive the bus. The four timing values are sampled when an access is accepted, so the host can change them while an access is in progress without disturbing it.

The device's command-latch and address-latch pins follow two host address bits. Software sends a command byte by writing into the command region and an address byte by writing into the address region. For a large device, a page-read start address goes out as address writes carrying bits 7:0, 16:9, 24:17 and then bit 25; bit 8 is skipped, and smaller devices send only the first three bytes. The top address bits select one of several banks. The chip enable of the selected bank goes low when the access starts and stays low between accesses, until the host addresses a different bank.

The host sees a busy flag and a one-cycle acknowledge at the end of the hold phase. Read data is taken from the bus at the moment output enable rises.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: After reset, every chip enable, write enable and output enable is high, the command and address latch pins are low, the data driver is off, and busy and acknowledge are low.
- R2: When req_i is high while busy_o is low, the access is accepted on that clock edge. For the next t_setup_i+1 cycles busy_o is high and both strobes stay high.
- R3: The setup phase is followed by t_strobe_i+1 cycles in which we_n_o is low on a write or oe_n_o is low on a read. The other strobe stays high for the whole access, and both strobes are never low together.
- R4: The strobe-low phase is followed by t_hold_i+1 hold cycles with both strobes high. In the cycle after the last hold cycle, ack_o is high for exactly one cycle and busy_o is low.
- R5: On a write, dq_oe_o is high and dq_o carries the accepted write byte from access cycle t_hiz_i+1 (counting the first setup cycle as 0) through the last hold cycle. At all other times dq_oe_o is low, and it is never high on a read.
- R6: On a read, rdata_o takes the value of dq_i from the last strobe-low cycle and holds it after the access ends.
- R7: The bank is addr_i[ADDR_W-1 -: log2(NUM_BANKS)]. Its ce_n_o bit goes low from the first setup cycle, stays low after the access, and is released only when an access to another bank is accepted. At most one ce_n_o bit is low at a time.
- R8: On a write, cle_o equals addr_i bit CLE_BIT (default 16) and ale_o equals addr_i bit ALE_BIT (default 17) of the accepted request, for every cycle of the access. Both pins are low on reads and between accesses.
- R9: Changing the timing inputs after an access is accepted has no effect on that access.
- R10: A request made while busy_o is high is ignored: it changes no chip enable and starts no access after the current one ends.
- R11: A timing value of 0 gives a phase of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host address: bank, command and address region bits |
| wdata_i | input | DATA_W | Write byte |
| t_setup_i | input | TIME_W | Setup phase length minus one |
| t_strobe_i | input | TIME_W | Strobe-low phase length minus one |
| t_hold_i | input | TIME_W | Hold phase length minus one |
| t_hiz_i | input | TIME_W | Cycle in which write data starts to drive, minus one |
| busy_o | output | 1 | Access in progress |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Captured read byte |
| ce_n_o | output | NUM_BANKS | Chip enables, active low |
| we_n_o | output | 1 | Write strobe, active low |
| oe_n_o | output | 1 | Output enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| dq_o | output | DATA_W | Bus output data |
| dq_oe_o | output | 1 | Bus output driver enable |
| dq_i | input | DATA_W | Bus input data |

## Verification
On every cycle, the assertions check that the two strobes are never low together and that at most one chip enable is low. They also check that the chip enables change only when an access is accepted, that the latch pins and the data driver appear only with output enable high, that the acknowledge is a single pulse that follows a hold cycle, and that the latched timing does not change during an access. The exact phase lengths, the cycle in which the driver turns on, the read capture value, the decoding of the region bits and the handling of requests made while busy can only be shown by the bench. It compares every cycle of directed and randomized accesses against a cycle-by-cycle expected schedule.

// File: rtl/nand_tc_pkg.sv
package nand_tc_pkg;
  localparam int TIME_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [TIME_W-1:0] setup;
    logic [TIME_W-1:0] strobe;
    logic [TIME_W-1:0] hold;
  } phase_cfg_t;
endpackage

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_tc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  phase_cfg_t cfg_i,
  output phase_e     phase_o,
  output logic       strobe_last_o,
  output logic       ack_o
);
  phase_e            phase_q;
  phase_cfg_t        cfg_q;
  logic [TIME_W-1:0] cnt_q;
  logic              ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cfg_q   <= '0;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_SETUP;
            cfg_q   <= cfg_i;
            cnt_q   <= cfg_i.setup;
          end
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            phase_q <= PH_STROBE;
            cnt_q   <= cfg_q.strobe;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt_q == '0) begin
            phase_q <= PH_HOLD;
            cnt_q   <= cfg_q.hold;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_q == '0) begin
            phase_q <= PH_IDLE;
            ack_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o       = phase_q;
  assign strobe_last_o = (phase_q == PH_STROBE) && (cnt_q == '0);
  assign ack_o         = ack_q;

  p_strobe_cnt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE) |-> (cnt_q <= cfg_q.strobe));
  p_ack_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);
  p_ack_after_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(phase_q == PH_HOLD));
  p_cfg_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && phase_q != PH_SETUP) |-> $stable(cfg_q));
endmodule

// File: rtl/nand_bank_sel.sv
module nand_bank_sel #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [NUM_BANKS-1:0] ce_n_o
);
  logic [BANK_W-1:0] bank_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q  <= '0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      bank_q  <= bank_i;
      valid_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_ce
    assign ce_n_o[i] = !(valid_q && (bank_q == BANK_W'(i)));
  end

  p_ce_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ce_n_o));
  p_ce_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(ce_n_o));
endmodule

// File: rtl/nand_data_path.sv
module nand_data_path
  import nand_tc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int EL_W = TIME_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [TIME_W-1:0] hiz_i,
  input  logic              busy_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [TIME_W-1:0] hiz_q;
  logic              wr_q;
  logic [EL_W-1:0]   elapsed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q   <= '0;
      hiz_q     <= '0;
      wr_q      <= 1'b0;
      elapsed_q <= '0;
    end else if (start_i) begin
      wdata_q   <= wdata_i;
      hiz_q     <= hiz_i;
      wr_q      <= wr_i;
      elapsed_q <= '0;
    end else if (busy_i && elapsed_q != '1) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= dq_i;
  end

  assign dq_oe_o = busy_i && wr_q && (elapsed_q > EL_W'(hiz_q));
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(rdata_q));
  p_drive_stays_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && busy_i && !start_i) |=> (dq_oe_o || !busy_i));
endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
  import nand_tc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 28,
  parameter int DATA_W    = 8,
  parameter int CLE_BIT   = 16,
  parameter int ALE_BIT   = 17,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [TIME_W-1:0]    t_setup_i,
  input  logic [TIME_W-1:0]    t_strobe_i,
  input  logic [TIME_W-1:0]    t_hold_i,
  input  logic [TIME_W-1:0]    t_hiz_i,
  output logic                 busy_o,
  output logic                 ack_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_BANKS-1:0] ce_n_o,
  output logic                 we_n_o,
  output logic                 oe_n_o,
  output logic                 cle_o,
  output logic                 ale_o,
  output logic [DATA_W-1:0]    dq_o,
  output logic                 dq_oe_o,
  input  logic [DATA_W-1:0]    dq_i
);
  phase_e     phase;
  phase_cfg_t cfg;
  logic       start, strobe_last, in_strobe;
  logic       wr_q, cle_q, ale_q;

  assign start = req_i && (phase == PH_IDLE);
  assign cfg   = '{setup: t_setup_i, strobe: t_strobe_i, hold: t_hold_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      cle_q <= 1'b0;
      ale_q <= 1'b0;
    end else if (start) begin
      wr_q  <= we_i;
      cle_q <= addr_i[CLE_BIT];
      ale_q <= addr_i[ALE_BIT];
    end
  end

  nand_phase_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .cfg_i        (cfg),
    .phase_o      (phase),
    .strobe_last_o(strobe_last),
    .ack_o        (ack_o)
  );

  nand_bank_sel #(.NUM_BANKS(NUM_BANKS)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .bank_i (addr_i[ADDR_W-1 -: BANK_W]),
    .ce_n_o (ce_n_o)
  );

  nand_data_path #(.DATA_W(DATA_W)) u_data (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .wr_i     (we_i),
    .wdata_i  (wdata_i),
    .hiz_i    (t_hiz_i),
    .busy_i   (busy_o),
    .capture_i(strobe_last && !wr_q),
    .dq_i     (dq_i),
    .dq_o     (dq_o),
    .dq_oe_o  (dq_oe_o),
    .rdata_o  (rdata_o)
  );

  assign busy_o    = (phase != PH_IDLE);
  assign in_strobe = (phase == PH_STROBE);
  assign we_n_o    = !(in_strobe && wr_q);
  assign oe_n_o    = !(in_strobe && !wr_q);
  assign cle_o     = busy_o && wr_q && cle_q;
  assign ale_o     = busy_o && wr_q && ale_q;

  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_n_o && !oe_n_o));
  p_latch_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cle_o || ale_o) |-> oe_n_o);
  p_drive_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (oe_n_o && busy_o));
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !busy_o);
  p_ce_during_access_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(&ce_n_o));
endmodule

// File: tb/tb_nand_strobe_ctrl.sv
module tb_nand_strobe_ctrl;
  localparam int NB = 4, AW = 28, DW = 8, TW = 8;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, dq_in = '0;
  logic [TW-1:0] t_set = '0, t_stb = '0, t_hld = '0, t_hiz = '0;
  logic          busy, ack, we_n, oe_n, cle, ale, dq_oe;
  logic [DW-1:0] rdata, dq_out;
  logic [NB-1:0] ce_n;

  int checks = 0, fails = 0, cur_bank = -1;

  always #5 clk = ~clk;

  nand_strobe_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .t_setup_i(t_set), .t_strobe_i(t_stb), .t_hold_i(t_hld),
    .t_hiz_i(t_hiz), .busy_o(busy), .ack_o(ack), .rdata_o(rdata),
    .ce_n_o(ce_n), .we_n_o(we_n), .oe_n_o(oe_n), .cle_o(cle), .ale_o(ale),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .dq_i(dq_in)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] exp_ce(int b);
    logic [NB-1:0] v = '1;
    if (b >= 0) v[b] = 1'b0;
    return v;
  endfunction

  function automatic logic [AW-1:0] mk_addr(int bank, bit c, bit a);
    logic [AW-1:0] v = AW'($urandom) & AW'(32'h0000_FFFF);
    v[AW-1 -: 2] = 2'(bank);
    v[16] = c;
    v[17] = a;
    return v;
  endfunction

  task automatic access(bit wr, int bank, bit c, bit a, logic [DW-1:0] d,
                        int s, int w, int h, int z, bit poke);
    logic [DW-1:0] rv = DW'($urandom);
    int n = s + w + h + 3;
    @(negedge clk);
    req = 1'b1; we = wr; addr = mk_addr(bank, c, a); wdata = d;
    t_set = TW'(s); t_stb = TW'(w); t_hld = TW'(h); t_hiz = TW'(z);
    dq_in = rv;
    @(negedge clk);
    req = 1'b0;
    // R9: disturb timing inputs mid-access
    t_set = TW'($urandom); t_stb = TW'($urandom);
    t_hld = TW'($urandom); t_hiz = TW'($urandom);
    cur_bank = bank;
    for (int k = 0; k <= n; k++) begin
      bit acc = (k < n);
      bit stb = (k >= s + 1) && (k < s + w + 2);
      bit drv = wr && acc && (k >= z + 1);
      chk("R2 busy", 32'(busy), 32'(acc));
      chk("R3 we_n", 32'(we_n), 32'(!(wr && stb)));
      chk("R3 oe_n", 32'(oe_n), 32'(!(!wr && stb)));
      chk("R4 ack", 32'(ack), 32'(k == n));
      chk("R5 dq_oe", 32'(dq_oe), 32'(drv));
      if (drv) chk("R5 dq_o", 32'(dq_out), 32'(d));
      chk("R7 ce_n", 32'(ce_n), 32'(exp_ce(cur_bank)));
      chk("R8 cle", 32'(cle), 32'(wr && c && acc));
      chk("R8 ale", 32'(ale), 32'(wr && a && acc));
      if (poke && k == 1) begin  // R10: request while busy
        req = 1'b1; we = 1'b1; addr = mk_addr((bank + 1) % NB, 1'b1, 1'b0);
      end
      if (poke && k == 2) req = 1'b0;
      @(negedge clk);
    end
    chk("R4 ack single", 32'(ack), 32'h0);
    chk("R10 no extra access", 32'(busy), 32'h0);
    chk("R7 ce kept", 32'(ce_n), 32'(exp_ce(cur_bank)));
    if (!wr) chk("R6 rdata", 32'(rdata), 32'(rv));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5177));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", 32'(ce_n), 32'(exp_ce(-1)));
    chk("R1 we_n", 32'(we_n), 32'h1);
    chk("R1 oe_n", 32'(oe_n), 32'h1);
    chk("R1 cle", 32'(cle), 32'h0);
    chk("R1 ale", 32'(ale), 32'h0);
    chk("R1 dq_oe", 32'(dq_oe), 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    chk("R1 ack", 32'(ack), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'(ce_n), 32'(exp_ce(-1)));
    // R11: all-zero timing, command write
    access(1'b1, 0, 1'b1, 1'b0, 8'h00, 0, 0, 0, 0, 1'b0);
    // R8: address bytes, same bank keeps CE low (R7)
    access(1'b1, 0, 1'b0, 1'b1, 8'h5A, 1, 2, 1, 0, 1'b0);
    access(1'b1, 0, 1'b0, 1'b1, 8'h13, 0, 1, 0, 2, 1'b0);
    // R6 read, same bank
    access(1'b0, 0, 1'b0, 1'b0, 8'h00, 2, 3, 1, 0, 1'b0);
    // R7 bank change, long phases
    access(1'b0, 2, 1'b0, 1'b0, 8'h00, 20, 20, 20, 0, 1'b0);
    // R5 driver never enabled when hiz exceeds the access
    access(1'b1, 2, 1'b0, 1'b0, 8'hC3, 2, 2, 2, 40, 1'b0);
    // R10 request during busy
    access(1'b1, 1, 1'b1, 1'b0, 8'h7E, 1, 1, 1, 1, 1'b1);
    access(1'b0, 3, 1'b0, 1'b0, 8'h00, 0, 0, 0, 0, 1'b1);
    for (int i = 0; i < 40; i++) begin
      access(1'($urandom), int'($urandom % NB), 1'($urandom), 1'($urandom),
             DW'($urandom), int'($urandom % 6), int'($urandom % 6),
             int'($urandom % 6), int'($urandom % 12), 1'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule